// File: doc/BRIEF.md
# MII Transmit Frame Integrity Monitor

This block sits passively on a 4-bit media-independent transmit interface and audits every frame that a MAC emits. It samples the data nibble, the enable and the error line on each transmit clock edge, locks onto the start-of-frame pattern, rebuilds bytes from nibbles, runs a CRC-32 over the frame body and checks the trailing frame check sequence. It also captures the type/length field and notices broadcast destinations.

The monitor separates a real end of frame from a short, spurious drop of the enable line. The enable line must stay low for a full interframe gap before the frame counts as finished. A shorter low spell inside a frame is recorded as a gap violation. The CRC keeps running across that low spell. A frame with a glitch therefore still shows a matching checksum when the dropout split no data.

At the end of each frame the block raises a one-cycle status strobe with the verdict flags, the body byte count and the type field. Three saturating counters total good frames, checksum failures and gap violations.

Top module: `mii_tx_monitor`

## Requirements
- R1: A frame is accepted only when its first nibbles, from the cycle the enable rises, are exactly fifteen nibbles of 0x5 followed by nibble 0xD. Any other start, or the enable dropping before that delimiter, reports statPreErr=1 at frame end.
- R2: A frame ends on the 24th consecutive sampled cycle with txEn low. statValid is high for exactly one cycle, and it is first seen after the 24th clock edge that sampled txEn low.
- R3: A low spell of txEn lasting 1 to 23 cycles after the delimiter sets statGapErr. The nibbles before and after the spell are checked as one continuous frame.
- R4: Nibbles arrive least significant nibble first, and bits go least significant bit first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and covers every body byte including the FCS. The FCS is the complement of the CRC over the earlier bytes, sent lowest byte first. The check passes when the register ends at 0xDEBB20E3, which is 0xC704DD7B in MSB-first notation. A failure sets statCrcErr, except on a preamble error.
- R5: statByteCount is the number of complete bytes after the delimiter, FCS included.
- R6: statTypeLen holds body bytes 12 (high) and 13 (low). statKind is 1 when the value is at most 1500, 2 for 0x0800, 3 for 0x0806, and 0 otherwise.
- R7: statBroadcast is 1 when body bytes 0 to 5 are all 0xFF.
- R8: Any cycle with txEr and txEn both high inside a frame sets statTxErr.
- R9: A frame whose body holds an odd nibble count sets statAlignErr.
- R10: statGood is 1 exactly when none of the CRC, gap, preamble, alignment and transmit-error flags is set.
- R11: cntGood, cntCrcErr and cntGapErr increment together with the status strobe and saturate at 2^CNT_W-1.
- R12: After reset, statValid, all flags, statByteCount and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEn | input | 1 | Transmit enable as seen on the interface |
| txEr | input | 1 | Transmit error as seen on the interface |
| txData | input | 4 | Transmit data nibble |
| statValid | output | 1 | One-cycle frame-end strobe |
| statGood | output | 1 | Frame passed every check |
| statCrcErr | output | 1 | Checksum mismatch |
| statGapErr | output | 1 | Short low spell inside the frame |
| statPreErr | output | 1 | Bad preamble or delimiter |
| statAlignErr | output | 1 | Odd nibble count |
| statTxErr | output | 1 | Error line seen during the frame |
| statBroadcast | output | 1 | All-ones destination |
| statByteCount | output | BYTE_W | Body bytes including FCS |
| statTypeLen | output | 16 | Type/length field |
| statKind | output | 2 | Type/length class |
| cntGood | output | CNT_W | Good frame counter |
| cntCrcErr | output | CNT_W | Checksum failure counter |
| cntGapErr | output | CNT_W | Gap violation counter |

## Verification
Two functions can act in the same cycle. In the cycle the enable returns after a short dropout, the gap violation is recorded while the CRC absorbs the next nibble. The bench provokes this by dropping the enable for one cycle and raising the error line on the first nibble after the return. That frame must report both the gap and transmit-error flags, still pass the checksum, and advance the gap counter without touching the checksum counter. A 23-cycle dropout and a 24-cycle dropout mark the boundary. The 24-cycle one must split the stream into a truncated frame with a checksum failure, followed by a preamble error.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef struct packed {
    logic clear;
    logic takeNibble;
    logic gapHit;
    logic preFail;
    logic frameEnd;
    logic errMark;
  } mtmStrobe_t;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_LEN   = 2'd1,
    KIND_IPV4  = 2'd2,
    KIND_ARP   = 2'd3
  } typeKind_e;

  function automatic logic [31:0] crcNibble(input logic [31:0] crcIn,
                                            input logic [3:0] nib);
    logic [31:0] c;
    c = crcIn;
    for (int b = 0; b < 4; b++) begin
      if (c[0] ^ nib[b]) c = (c >> 1) ^ CRC_POLY;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/mtm_ctrl.sv
module mtm_ctrl
  import mtm_pkg::*;
#(
  parameter int GAP_CYCLES  = 24,
  parameter int PRE_NIBBLES = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       txEr,
  input  logic [3:0] txData,
  output mtmStrobe_t strb
);

  localparam int LOW_W = $clog2(GAP_CYCLES + 1);
  localparam int PRE_W = $clog2(PRE_NIBBLES + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(GAP_CYCLES - 1);
  localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_NIBBLES);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_BODY, S_SKIP} state_e;

  state_e           state, stateNext;
  logic [LOW_W-1:0] lowCnt, lowCntNext;
  logic [PRE_W-1:0] preCnt, preCntNext, preBase;
  logic             preStep;

  always_comb begin
    stateNext  = state;
    preCntNext = preCnt;
    strb       = '0;
    strb.errMark = txEn && txEr;
    if (state == S_IDLE || txEn) lowCntNext = '0;
    else if (lowCnt == LOW_LAST)  lowCntNext = lowCnt;
    else                          lowCntNext = lowCnt + 1'b1;

    preStep = txEn && (state == S_IDLE || state == S_PRE);
    preBase = (state == S_IDLE) ? '0 : preCnt;
    if (state == S_IDLE && txEn) strb.clear = 1'b1;

    if (preStep) begin
      if (txData == 4'h5 && preBase < PRE_FULL) begin
        preCntNext = preBase + 1'b1;
        stateNext  = S_PRE;
      end else if (txData == 4'hD && preBase == PRE_FULL) begin
        stateNext = S_BODY;
      end else begin
        strb.preFail = 1'b1;
        stateNext    = S_SKIP;
      end
    end

    case (state)
      S_PRE: if (!txEn) begin
        strb.preFail = 1'b1;
        stateNext    = S_SKIP;
      end
      S_BODY: begin
        if (txEn) begin
          strb.takeNibble = 1'b1;
          strb.gapHit     = (lowCnt != '0);
        end else if (lowCnt == LOW_LAST) begin
          strb.frameEnd = 1'b1;
          stateNext     = S_IDLE;
        end
      end
      S_SKIP: if (!txEn && lowCnt == LOW_LAST) begin
        strb.frameEnd = 1'b1;
        stateNext     = S_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      lowCnt <= '0;
      preCnt <= '0;
    end else begin
      state  <= stateNext;
      lowCnt <= lowCntNext;
      preCnt <= preCntNext;
    end
  end

  AST_END_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |-> (!txEn && !$past(txEn)));  // R2
  AST_NO_NIBBLE_IN_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PRE || state == S_SKIP) |-> !strb.takeNibble);  // R1

endmodule

// File: rtl/mtm_datapath.sv
module mtm_datapath
  import mtm_pkg::*;
#(
  parameter int BYTE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mtmStrobe_t        strb,
  input  logic [3:0]        txData,
  output logic              statValid,
  output logic              statGood,
  output logic              statCrcErr,
  output logic              statGapErr,
  output logic              statPreErr,
  output logic              statAlignErr,
  output logic              statTxErr,
  output logic              statBroadcast,
  output logic [BYTE_W-1:0] statByteCount,
  output logic [15:0]       statTypeLen,
  output logic [1:0]        statKind,
  output logic [CNT_W-1:0]  cntGood,
  output logic [CNT_W-1:0]  cntCrcErr,
  output logic [CNT_W-1:0]  cntGapErr
);

  localparam logic [BYTE_W-1:0] ADDR_END = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] TYPE_HI  = BYTE_W'(12);
  localparam logic [BYTE_W-1:0] TYPE_LO  = BYTE_W'(13);
  localparam logic [15:0]       LEN_MAX  = 16'd1500;

  logic [31:0]       crcReg;
  logic              nibPhase;
  logic [3:0]        loNib;
  logic [BYTE_W-1:0] byteCnt;
  logic              bcastRun, gapF, preF, txErrF;
  logic [15:0]       typeLenReg;
  logic [7:0]        newByte;
  logic              endCrcBad, endAlignBad, endGood;
  typeKind_e         endKind;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_comb begin
    newByte     = {txData, loNib};
    endCrcBad   = !preF && (crcReg != CRC_RESIDUE);
    endAlignBad = !preF && nibPhase;
    endGood     = !(endCrcBad || gapF || preF || endAlignBad || txErrF);
    if (typeLenReg <= LEN_MAX)     endKind = KIND_LEN;
    else if (typeLenReg == 16'h0800) endKind = KIND_IPV4;
    else if (typeLenReg == 16'h0806) endKind = KIND_ARP;
    else                             endKind = KIND_OTHER;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg        <= CRC_INIT;
      nibPhase      <= 1'b0;
      loNib         <= '0;
      byteCnt       <= '0;
      bcastRun      <= 1'b0;
      typeLenReg    <= '0;
      gapF          <= 1'b0;
      preF          <= 1'b0;
      txErrF        <= 1'b0;
      statValid     <= 1'b0;
      statGood      <= 1'b0;
      statCrcErr    <= 1'b0;
      statGapErr    <= 1'b0;
      statPreErr    <= 1'b0;
      statAlignErr  <= 1'b0;
      statTxErr     <= 1'b0;
      statBroadcast <= 1'b0;
      statByteCount <= '0;
      statTypeLen   <= '0;
      statKind      <= '0;
      cntGood       <= '0;
      cntCrcErr     <= '0;
      cntGapErr     <= '0;
    end else begin
      statValid <= strb.frameEnd;
      if (strb.clear) begin
        crcReg     <= CRC_INIT;
        nibPhase   <= 1'b0;
        byteCnt    <= '0;
        bcastRun   <= 1'b1;
        typeLenReg <= '0;
        gapF       <= 1'b0;
        preF       <= strb.preFail;
        txErrF     <= strb.errMark;
      end else begin
        if (strb.errMark) txErrF <= 1'b1;
        if (strb.gapHit)  gapF   <= 1'b1;
        if (strb.preFail) preF   <= 1'b1;
        if (strb.takeNibble) begin
          crcReg   <= crcNibble(crcReg, txData);
          nibPhase <= ~nibPhase;
          if (!nibPhase) begin
            loNib <= txData;
          end else begin
            if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
            if (byteCnt < ADDR_END && newByte != 8'hFF) bcastRun <= 1'b0;
            if (byteCnt == TYPE_HI) typeLenReg[15:8] <= newByte;
            if (byteCnt == TYPE_LO) typeLenReg[7:0]  <= newByte;
          end
        end
      end
      if (strb.frameEnd) begin
        statGood      <= endGood;
        statCrcErr    <= endCrcBad;
        statGapErr    <= gapF;
        statPreErr    <= preF;
        statAlignErr  <= endAlignBad;
        statTxErr     <= txErrF;
        statBroadcast <= !preF && bcastRun && (byteCnt >= ADDR_END);
        statByteCount <= byteCnt;
        statTypeLen   <= typeLenReg;
        statKind      <= endKind;
        if (endGood)   cntGood   <= satInc(cntGood);
        if (endCrcBad) cntCrcErr <= satInc(cntCrcErr);
        if (gapF)      cntGapErr <= satInc(cntGapErr);
      end
    end
  end

  AST_CRC_HOLDS_IN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.takeNibble && !strb.clear) |=> $stable(crcReg));  // R3
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    statValid |=> !statValid);  // R2
  AST_GOOD_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntGood != '0) |=> (cntGood != '0));  // R11
  AST_GAP_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntGapErr != '0) |=> (cntGapErr != '0));  // R11

endmodule

// File: rtl/mii_tx_monitor.sv
module mii_tx_monitor
  import mtm_pkg::*;
#(
  parameter int GAP_CYCLES  = 24,
  parameter int PRE_NIBBLES = 15,
  parameter int BYTE_W      = 16,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              txEr,
  input  logic [3:0]        txData,
  output logic              statValid,
  output logic              statGood,
  output logic              statCrcErr,
  output logic              statGapErr,
  output logic              statPreErr,
  output logic              statAlignErr,
  output logic              statTxErr,
  output logic              statBroadcast,
  output logic [BYTE_W-1:0] statByteCount,
  output logic [15:0]       statTypeLen,
  output logic [1:0]        statKind,
  output logic [CNT_W-1:0]  cntGood,
  output logic [CNT_W-1:0]  cntCrcErr,
  output logic [CNT_W-1:0]  cntGapErr
);

  mtmStrobe_t strb;

  mtm_ctrl #(.GAP_CYCLES(GAP_CYCLES), .PRE_NIBBLES(PRE_NIBBLES)) uCtrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txData(txData), .strb(strb)
  );

  mtm_datapath #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData),
    .statValid(statValid), .statGood(statGood), .statCrcErr(statCrcErr),
    .statGapErr(statGapErr), .statPreErr(statPreErr), .statAlignErr(statAlignErr),
    .statTxErr(statTxErr), .statBroadcast(statBroadcast),
    .statByteCount(statByteCount), .statTypeLen(statTypeLen), .statKind(statKind),
    .cntGood(cntGood), .cntCrcErr(cntCrcErr), .cntGapErr(cntGapErr)
  );

  AST_STATUS_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !$past(txEn));  // R2
  AST_GOOD_IS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statGood) |-> !(statCrcErr || statGapErr || statPreErr ||
                                  statAlignErr || statTxErr));  // R10

endmodule

// File: tb/sim_mii_tx_monitor.sv
`timescale 1ns/1ps
module sim_mii_tx_monitor;

  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0, txEn = 1'b0, txEr = 1'b0;
  logic [3:0] txData = '0;
  logic statValid, statGood, statCrcErr, statGapErr, statPreErr, statAlignErr;
  logic statTxErr, statBroadcast;
  logic [15:0] statByteCount, statTypeLen;
  logic [1:0] statKind;
  logic [CW-1:0] cntGood, cntCrcErr, cntGapErr;

  always #2.5 clk = ~clk;

  mii_tx_monitor #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txData(txData),
    .statValid(statValid), .statGood(statGood), .statCrcErr(statCrcErr),
    .statGapErr(statGapErr), .statPreErr(statPreErr), .statAlignErr(statAlignErr),
    .statTxErr(statTxErr), .statBroadcast(statBroadcast),
    .statByteCount(statByteCount), .statTypeLen(statTypeLen), .statKind(statKind),
    .cntGood(cntGood), .cntCrcErr(cntCrcErr), .cntGapErr(cntGapErr)
  );

  typedef struct packed {
    logic [7:0]  payLen;
    logic        bcast;
    logic [15:0] typeLen;
    logic        badCrc;
    logic [7:0]  glitchAt;
    logic [4:0]  glitchLen;
    logic        extraNib;
    logic [7:0]  erAt;
    logic [1:0]  preMode;
    logic        eCrc, eGap, ePre, eAlign, eTx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd46, 1'b0, 16'h0800, 1'b0, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd28, 1'b1, 16'h0806, 1'b0, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd20, 1'b0, 16'h05DC, 1'b0, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd10, 1'b0, 16'h05DD, 1'b0, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd30, 1'b0, 16'h0800, 1'b1, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd40, 1'b0, 16'h0800, 1'b0, 8'd40, 5'd1,  1'b0, 8'hFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd40, 1'b0, 16'h0806, 1'b0, 8'd61, 5'd23, 1'b0, 8'hFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd20, 1'b0, 16'h0800, 1'b0, 8'd0,  5'd0,  1'b0, 8'd30, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'd20, 1'b0, 16'h0800, 1'b0, 8'd0,  5'd0,  1'b1, 8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'd20, 1'b0, 16'h0800, 1'b0, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{8'd20, 1'b0, 16'h0800, 1'b0, 8'd0,  5'd0,  1'b0, 8'hFF, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{8'd30, 1'b0, 16'h0800, 1'b0, 8'd50, 5'd1,  1'b0, 8'd50, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  int nChk = 0, nBad = 0;
  int expGood = 0, expCrc = 0, expGap = 0;
  logic midSeen;
  logic midCrc, midGap, midGood;
  logic [15:0] midBytes;
  logic [CW-1:0] midCntCrc;
  logic [7:0] fb [0:127];

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic int kindOf(input logic [15:0] t);
    if (t <= 16'd1500) return 1;
    if (t == 16'h0800) return 2;
    if (t == 16'h0806) return 3;
    return 0;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic step(input logic en, input logic er, input logic [3:0] d);
    @(negedge clk);
    if (statValid && !midSeen) begin
      midSeen   = 1'b1;
      midCrc    = statCrcErr;
      midGap    = statGapErr;
      midGood   = statGood;
      midBytes  = statByteCount;
      midCntCrc = cntCrcErr;
    end
    txEn = en; txEr = er; txData = d;
  endtask

  task automatic sendFrame(input vec_t v, input string tag);
    int n, lat, nPre;
    logic [31:0] c;
    logic eGood;
    midSeen = 1'b0;
    n = 14 + v.payLen;
    for (int i = 0; i < 6; i++) fb[i] = v.bcast ? 8'hFF : 8'(8'h02 + i * 8'h0F);
    fb[1] = v.bcast ? 8'hFF : 8'h11;
    for (int i = 0; i < 6; i++) fb[6 + i] = 8'(8'h02 + i * 8'h31);
    fb[12] = v.typeLen[15:8];
    fb[13] = v.typeLen[7:0];
    for (int i = 0; i < int'(v.payLen); i++) fb[14 + i] = 8'(i * 7 + 3);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) c = crcByte(c, fb[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) fb[n + i] = c[8*i +: 8];
    if (v.badCrc) fb[n + 3] = fb[n + 3] ^ 8'h01;
    n = n + 4;
    nPre = (v.preMode == 2'd1) ? 13 : 15;
    for (int i = 0; i < nPre; i++) step(1'b1, 1'b0, (v.preMode == 2'd2 && i == 3) ? 4'h7 : 4'h5);
    step(1'b1, 1'b0, 4'hD);
    for (int i = 0; i < 2 * n; i++) begin
      if (v.glitchAt != 0 && i == int'(v.glitchAt))
        for (int g = 0; g < int'(v.glitchLen); g++) step(1'b0, 1'b0, 4'h0);
      step(1'b1, (i == int'(v.erAt)), (i % 2 == 0) ? fb[i/2][3:0] : fb[i/2][7:4]);
    end
    if (v.extraNib) step(1'b1, 1'b0, 4'hA);
    step(1'b0, 1'b0, 4'h0);
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (statValid) begin lat = k; break; end
    end
    eGood = !(v.eCrc || v.eGap || v.ePre || v.eAlign || v.eTx);
    if (eGood) expGood++;
    if (v.eCrc) expCrc++;
    if (v.eGap) expGap++;
    chk({tag, " R2 end latency"}, lat, 24);
    chk({tag, " R10 good"}, statGood, eGood);
    chk({tag, " R4 crc"}, statCrcErr, v.eCrc);
    chk({tag, " R3 gap"}, statGapErr, v.eGap);
    chk({tag, " R1 preamble"}, statPreErr, v.ePre);
    chk({tag, " R9 align"}, statAlignErr, v.eAlign);
    chk({tag, " R8 txerr"}, statTxErr, v.eTx);
    if (!v.ePre) begin
      chk({tag, " R5 bytes"}, statByteCount, n);
      chk({tag, " R6 typelen"}, statTypeLen, v.typeLen);
      chk({tag, " R6 kind"}, statKind, kindOf(v.typeLen));
      chk({tag, " R7 bcast"}, statBroadcast, v.bcast);
    end
    chk({tag, " R11 cntGood"}, cntGood, sat(expGood));
    chk({tag, " R11 cntCrc"}, cntCrcErr, sat(expCrc));
    chk({tag, " R11 cntGap"}, cntGapErr, sat(expGap));
    @(negedge clk);
    chk({tag, " R2 single pulse"}, statValid, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    vec_t s;
    midSeen = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 statValid", statValid, 0);
    chk("R12 flags", {statGood, statCrcErr, statGapErr, statPreErr, statAlignErr, statTxErr, statBroadcast}, 0);
    chk("R12 bytes", statByteCount, 0);
    chk("R12 counters", {cntGood, cntCrcErr, cntGapErr}, 0);

    for (int i = 0; i < NV; i++) sendFrame(VECS[i], $sformatf("vec%0d", i));

    // R3 boundary: 24 low cycles split the stream into two frames
    s = VECS[0];
    s.payLen = 8'd20; s.glitchAt = 8'd2; s.glitchLen = 5'd24;
    s.eCrc = 1'b0; s.eGap = 1'b0; s.ePre = 1'b1; s.eAlign = 1'b0; s.eTx = 1'b0;
    expCrc++;
    sendFrame(s, "split24");
    chk("R3 split first seen", midSeen, 1);
    chk("R3 split first crc", midCrc, 1);
    chk("R3 split first gap", midGap, 0);
    chk("R10 split first good", midGood, 0);
    chk("R5 split first bytes", midBytes, 1);
    chk("R11 split cntCrc", midCntCrc, sat(expCrc));

    // R11 saturation of good counter
    for (int i = 0; i < 4; i++) sendFrame(VECS[0], $sformatf("sat%0d", i));
    chk("R11 good saturated", cntGood, CMAX);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule